// File: doc/BRIEF.md
# Dual-Lane ADC Sample Serializer

This block turns the parallel 14-bit results of two converter channels (A and B) into serial bit streams. Each channel drives a pair of lanes, lane 1 and lane 0. The lanes change only on rising edges of the block clock, and that clock is forwarded to the receiver as `out_clk`. Before a sample is shifted, its code is clamped for out-of-range inputs and converted to the selected number format. The word goes out most significant bit first. A per-lane frame strobe marks the first bit of every word.

In single-lane mode every sample of a channel goes out on lane 1, one bit per clock. The block takes a new sample every 14 clocks, and lane 0 is disabled. In dual-lane mode consecutive samples alternate between lane 1 and lane 0. Each bit is held for two clocks, so one lane needs 28 clocks per word, and the two lanes together keep the same 14-clock sample rate. A single `samp_take` strobe tells the source when to present the next sample for both channels. Power-down freezes every lane on its last level. After release, the next word is a freshly taken sample that starts on lane 1.

Top module: `adc_lane_serializer`

## Requirements
- R1: A channel's under-range flag forces the pre-format code to 0, and its over-range flag forces it to 16383. When both flags are set, under-range wins. With no flag set, the raw sample is used.
- R2: With `twos_comp` high, bit 13 of the code after R1 is inverted and all other bits pass unchanged. With `twos_comp` low, the code is plain offset binary.
- R3: In single-lane mode the sample present at the rising edge that ends a cycle with `samp_take` high appears on lane 1 from the next cycle on. It goes out bit 13 first, one bit per clock. `lane_frm` for that lane is high only during bit 13. `samp_take` is high once every 14 clocks.
- R4: Lane bit map: bit 0 is A lane 0, bit 1 is A lane 1, bit 2 is B lane 0, bit 3 is B lane 1. Lane-1 enables are always high. In single-lane mode the lane-0 enables are low and lane-0 data does not toggle.
- R5: In dual-lane mode samples alternate, starting on lane 1. Each bit lasts two clocks, and `lane_frm` is high for both clocks of bit 13. The lane-0 word starts 14 clocks after the lane-1 word, and the lane-0 enables are high.
- R6: While `pwr_down` is high, `samp_take` is low, and all lane data and frame outputs keep their values. This also holds when power-down starts in a cycle in which a take was due.
- R7: In the first cycle after `pwr_down` falls, `samp_take` is high. The sample taken then goes out on lane 1 with its frame strobe.
- R8: A change of `dual_mode` gives one cycle with `samp_take` low, even when a take was due. The lane-0 enables follow the new mode from the next cycle, and the next word starts on lane 1.
- R9: Channels A and B carry their own samples and flags, and their lanes run in the same slots.
- R10: `out_clk` follows `clk`, so lane data only changes on the rising edge of `out_clk`.
- R11: During reset all lane data and frame outputs are 0, and the lane-0 enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1: dual-lane, 0: single-lane |
| twos_comp | input | 1 | 1: two's complement, 0: offset binary |
| pwr_down | input | 1 | Freeze all lanes |
| samp_a | input | 14 | Channel A raw conversion result |
| samp_b | input | 14 | Channel B raw conversion result |
| under_rng | input | 2 | Under-range flags, bit 0 A, bit 1 B |
| over_rng | input | 2 | Over-range flags, bit 0 A, bit 1 B |
| samp_take | output | 1 | Samples are captured at the coming rising edge |
| out_clk | output | 1 | Forwarded clock |
| lane_dat | output | 4 | Lane data, map per R4 |
| lane_oe | output | 4 | Lane output enables, map per R4 |
| lane_frm | output | 4 | First-bit strobe per lane, map per R4 |

## Verification
Two events can land on the same edge: a scheduled sample take, and either the start of power-down or a change of lane mode. The bench waits for a cycle in which `samp_take` is already high and then raises `pwr_down` in that cycle. It expects the take to be suppressed, the lanes to freeze and, after release, the next word to come from the sample presented after release. A mode switch is provoked in a take cycle in the same way. It is judged by `samp_take` dropping for exactly one cycle, the lane-0 enables following the new mode, and the following words landing on lane 1 then lane 0 with the correct bit timing.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  localparam int unsigned SAMP_W = 14;
  localparam int unsigned N_CH   = 2;

  typedef enum logic {
    LANE_ZERO = 1'b0,
    LANE_ONE  = 1'b1
  } lane_sel_e;

  // clamp for range flags, then optional sign-bit flip
  function automatic logic [SAMP_W-1:0] fmt_code(
    input logic [SAMP_W-1:0] raw,
    input logic              under,
    input logic              over,
    input logic              twos
  );
    logic [SAMP_W-1:0] c;
    if (under)     c = '0;
    else if (over) c = '1;
    else           c = raw;
    c[SAMP_W-1] = c[SAMP_W-1] ^ twos;
    return c;
  endfunction

  function automatic lane_sel_e next_lane_after(input lane_sel_e cur, input logic dual);
    if (!dual) return LANE_ONE;
    return (cur == LANE_ONE) ? LANE_ZERO : LANE_ONE;
  endfunction
endpackage

// File: rtl/ser_code_fmt.sv
module ser_code_fmt
  import adc_ser_pkg::*;
(
  input  logic [SAMP_W-1:0] raw,
  input  logic              under,
  input  logic              over,
  input  logic              twos,
  output logic [SAMP_W-1:0] code
);
  assign code = fmt_code(raw, under, over, twos);

  always_comb begin
    if (under && !twos)
      AST_UNDER_ZERO: assert (code == '0); // R1
    if (over && !under && !twos)
      AST_OVER_FULL: assert (code == '1); // R1
  end
endmodule

// File: rtl/ser_sequencer.sv
module ser_sequencer
  import adc_ser_pkg::*;
#(
  parameter int unsigned W = SAMP_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic dual_mode,
  output logic restart,
  output logic load_lane1,
  output logic load_lane0,
  output logic dual_q,
  output logic take
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic          started;
  lane_sel_e     next_lane;
  logic          mode_chg;
  logic          frame_end;
  logic          load;

  assign mode_chg   = (dual_mode != dual_q);
  assign restart    = pwr_down | mode_chg;
  assign frame_end  = (cnt == LAST);
  assign load       = !restart && (!started || frame_end);
  assign load_lane1 = load && (!dual_q || next_lane == LANE_ONE);
  assign load_lane0 = load && dual_q && (next_lane == LANE_ZERO);
  assign take       = load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      started   <= 1'b0;
      next_lane <= LANE_ONE;
      dual_q    <= 1'b0;
    end else if (restart) begin
      cnt       <= '0;
      started   <= 1'b0;
      next_lane <= LANE_ONE;
      dual_q    <= dual_mode;
    end else if (load) begin
      cnt       <= '0;
      started   <= 1'b1;
      next_lane <= next_lane_after(next_lane, dual_q);
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take); // R3

  AST_ONE_LANE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_lane1 && load_lane0)); // R5
endmodule

// File: rtl/ser_lane.sv
module ser_lane
  import adc_ser_pkg::*;
#(
  parameter int unsigned W = SAMP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         restart,
  input  logic         dual,
  input  logic [W-1:0] word,
  output logic         dat,
  output logic         frm
);
  logic [W-1:0] shreg;
  logic         sub;
  logic         active;
  logic         shift;

  assign dat   = shreg[W-1];
  assign shift = active && (!dual || sub);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      sub    <= 1'b0;
      active <= 1'b0;
      frm    <= 1'b0;
    end else if (load) begin
      shreg  <= word;
      sub    <= 1'b0;
      active <= 1'b1;
      frm    <= 1'b1;
    end else if (restart) begin
      active <= 1'b0;
    end else if (shift) begin
      shreg <= {shreg[W-2:0], 1'b0};
      sub   <= 1'b0;
      frm   <= 1'b0;
    end else if (active) begin
      sub <= 1'b1;
    end
  end

  AST_FRM_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load)) |-> (frm && dat == $past(word[W-1]))); // R3
endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
  import adc_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_mode,
  input  logic              twos_comp,
  input  logic              pwr_down,
  input  logic [SAMP_W-1:0] samp_a,
  input  logic [SAMP_W-1:0] samp_b,
  input  logic [N_CH-1:0]   under_rng,
  input  logic [N_CH-1:0]   over_rng,
  output logic              samp_take,
  output logic              out_clk,
  output logic [2*N_CH-1:0] lane_dat,
  output logic [2*N_CH-1:0] lane_oe,
  output logic [2*N_CH-1:0] lane_frm
);
  logic restart;
  logic load_lane1;
  logic load_lane0;
  logic dual_q;
  logic [SAMP_W-1:0] raw  [N_CH];
  logic [SAMP_W-1:0] code [N_CH];

  assign out_clk = clk;
  assign raw[0]  = samp_a;
  assign raw[1]  = samp_b;

  ser_sequencer #(.W(SAMP_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .dual_mode (dual_mode),
    .restart   (restart),
    .load_lane1(load_lane1),
    .load_lane0(load_lane0),
    .dual_q    (dual_q),
    .take      (samp_take)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    ser_code_fmt u_fmt (
      .raw  (raw[ch]),
      .under(under_rng[ch]),
      .over (over_rng[ch]),
      .twos (twos_comp),
      .code (code[ch])
    );

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      localparam int unsigned IDX = ch * 2 + ln;
      ser_lane #(.W(SAMP_W)) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   ((ln == 1) ? load_lane1 : load_lane0),
        .restart(restart),
        .dual   (dual_q),
        .word   (code[ch]),
        .dat    (lane_dat[IDX]),
        .frm    (lane_frm[IDX])
      );
      assign lane_oe[IDX] = (ln == 1) ? 1'b1 : dual_q;
    end

    AST_LANE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_oe[ch*2] && !$past(lane_oe[ch*2])) |-> $stable(lane_dat[ch*2])); // R4
  end

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> ($stable(lane_dat) && $stable(lane_frm))); // R6
endmodule

// File: tb/test_adc_lane_serializer.sv
`timescale 1ns/1ps
module test_adc_lane_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual_mode = 1'b0;
  logic        twos_comp = 1'b0;
  logic        pwr_down = 1'b0;
  logic [13:0] samp_a = '0;
  logic [13:0] samp_b = '0;
  logic [1:0]  under_rng = '0;
  logic [1:0]  over_rng = '0;
  logic        samp_take;
  logic        out_clk;
  logic [3:0]  lane_dat;
  logic [3:0]  lane_oe;
  logic [3:0]  lane_frm;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  adc_lane_serializer i_adc_lane_serializer (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .twos_comp(twos_comp),
    .pwr_down(pwr_down), .samp_a(samp_a), .samp_b(samp_b),
    .under_rng(under_rng), .over_rng(over_rng), .samp_take(samp_take),
    .out_clk(out_clk), .lane_dat(lane_dat), .lane_oe(lane_oe), .lane_frm(lane_frm)
  );

  // fields: raw[30:17] under[16] over[15] twos[14] expected[13:0]
  localparam logic [30:0] VEC [10] = '{
    {14'h1234, 1'b0, 1'b0, 1'b0, 14'h1234},
    {14'h1234, 1'b0, 1'b0, 1'b1, 14'h3234},
    {14'h2AAA, 1'b0, 1'b0, 1'b0, 14'h2AAA},
    {14'h2AAA, 1'b0, 1'b0, 1'b1, 14'h0AAA},
    {14'h1555, 1'b1, 1'b0, 1'b0, 14'h0000},
    {14'h1555, 1'b0, 1'b1, 1'b0, 14'h3FFF},
    {14'h1555, 1'b1, 1'b0, 1'b1, 14'h2000},
    {14'h0001, 1'b0, 1'b1, 1'b1, 14'h1FFF},
    {14'h1555, 1'b1, 1'b1, 1'b0, 14'h0000},
    {14'h3FFF, 1'b0, 1'b0, 1'b1, 14'h1FFF}
  };

  function automatic logic [13:0] ref_code(input logic [13:0] raw, input logic u,
                                           input logic o, input logic t);
    if (u) return t ? 14'h2000 : 14'h0000;
    if (o) return t ? 14'h1FFF : 14'h3FFF;
    return {raw[13] ^ t, raw[12:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog R3 actual=%0d expected<20000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic wait_take();
    while (!samp_take) @(negedge clk);
  endtask

  // single-lane word capture on lanes 1 and 3; returns words and timing flags
  task automatic get_single(output logic [13:0] wa, output logic [13:0] wb,
                            output logic frm_ok, output logic take_ok);
    frm_ok = 1'b1;
    take_ok = 1'b1;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      wa[13-k] = lane_dat[1];
      wb[13-k] = lane_dat[3];
      if ((lane_frm[1] !== (k == 0)) || (lane_frm[3] !== (k == 0))) frm_ok = 1'b0;
      if (samp_take !== (k == 13)) take_ok = 1'b0;
    end
  endtask

  initial begin
    logic [13:0] wa, wb, a1, a0, b1, b0;
    logic fo, to, rep_ok;
    logic [3:0] held_d, held_f;
    logic pd_ok;

    repeat (3) @(negedge clk);
    check("R11 reset data", {28'd0, lane_dat}, 32'd0);
    check("R11 reset frame", {28'd0, lane_frm}, 32'd0);
    check("R11 R4 reset enables", {28'd0, lane_oe}, 32'hA);
    rst_n = 1'b1;

    check("R10 out_clk low at negedge", {31'd0, out_clk}, 32'd0);
    @(posedge clk); #1;
    check("R10 out_clk high after posedge", {31'd0, out_clk}, 32'd1);
    @(negedge clk);

    // table walk in single-lane mode
    for (int i = 0; i < 10; i++) begin
      logic [30:0] v;
      v = VEC[i];
      wait_take();
      samp_a = v[30:17];
      samp_b = ~v[30:17];
      under_rng = {v[16], v[16]};
      over_rng = {v[15], v[15]};
      twos_comp = v[14];
      get_single(wa, wb, fo, to);
      check($sformatf("R1 R2 R3 chA vec%0d", i), {18'd0, wa}, {18'd0, v[13:0]});
      check($sformatf("R9 chB vec%0d", i), {18'd0, wb},
            {18'd0, ref_code(~v[30:17], v[16], v[15], v[14])});
      check($sformatf("R3 frame vec%0d", i), {31'd0, fo}, 32'd1);
      check($sformatf("R3 take period vec%0d", i), {31'd0, to}, 32'd1);
    end
    check("R4 single enables", {28'd0, lane_oe}, 32'hA);

    // independent per-channel flags
    under_rng = 2'b01; over_rng = 2'b10; twos_comp = 1'b0;
    samp_a = 14'h0F0F; samp_b = 14'h00FF;
    wait_take();
    get_single(wa, wb, fo, to);
    check("R9 R1 A under B over A", {18'd0, wa}, 32'h0);
    check("R9 R1 A under B over B", {18'd0, wb}, 32'h3FFF);
    under_rng = 2'b00; over_rng = 2'b00;

    // power-down raised in a take cycle
    wait_take();
    pwr_down = 1'b1;
    #1;
    check("R6 take suppressed by power-down", {31'd0, samp_take}, 32'd0);
    @(negedge clk);
    held_d = lane_dat;
    held_f = lane_frm;
    pd_ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (lane_dat !== held_d || lane_frm !== held_f || samp_take !== 1'b0) pd_ok = 1'b0;
    end
    check("R6 lanes frozen", {31'd0, pd_ok}, 32'd1);
    pwr_down = 1'b0;
    samp_a = 14'h2C3D; samp_b = 14'h1111;
    #1;
    check("R7 take right after release", {31'd0, samp_take}, 32'd1);
    get_single(wa, wb, fo, to);
    check("R7 post-release word A", {18'd0, wa}, 32'h2C3D);
    check("R7 post-release word B", {18'd0, wb}, 32'h1111);
    check("R7 post-release frame", {31'd0, fo}, 32'd1);

    // mode change in a take cycle
    wait_take();
    dual_mode = 1'b1;
    #1;
    check("R8 take suppressed by mode change", {31'd0, samp_take}, 32'd0);
    @(negedge clk);
    check("R8 take after restart", {31'd0, samp_take}, 32'd1);
    check("R8 R5 dual enables", {28'd0, lane_oe}, 32'hF);

    samp_a = 14'h1357; samp_b = 14'h2468;
    rep_ok = 1'b1;
    for (int t = 1; t <= 42; t++) begin
      @(negedge clk);
      if (t <= 28) begin
        if ((t % 2) == 1) begin
          a1[13-(t-1)/2] = lane_dat[1];
          b1[13-(t-1)/2] = lane_dat[3];
        end else if (lane_dat[1] !== a1[13-(t-1)/2] || lane_dat[3] !== b1[13-(t-1)/2])
          rep_ok = 1'b0;
        if (t <= 2) check($sformatf("R5 lane1 frame t%0d", t), {28'd0, lane_frm}, 32'hA);
        if (t == 3) check("R5 lane1 frame ends", {31'd0, lane_frm[1]}, 32'd0);
      end
      if (t >= 15) begin
        if ((t % 2) == 1) begin
          a0[13-(t-15)/2] = lane_dat[0];
          b0[13-(t-15)/2] = lane_dat[2];
        end else if (lane_dat[0] !== a0[13-(t-15)/2] || lane_dat[2] !== b0[13-(t-15)/2])
          rep_ok = 1'b0;
        if (t == 15) check("R5 lane0 frame", {30'd0, lane_frm[2], lane_frm[0]}, 32'h3);
      end
      if (t == 14) begin
        check("R5 take at 14", {31'd0, samp_take}, 32'd1);
        samp_a = 14'h3ACE; samp_b = 14'h0F0F;
      end
      if (t == 28) check("R5 take at 28", {31'd0, samp_take}, 32'd1);
    end
    check("R5 lane1 word A", {18'd0, a1}, 32'h1357);
    check("R5 lane1 word B", {18'd0, b1}, 32'h2468);
    check("R5 lane0 word A", {18'd0, a0}, 32'h3ACE);
    check("R5 lane0 word B", {18'd0, b0}, 32'h0F0F);
    check("R5 two clocks per bit", {31'd0, rep_ok}, 32'd1);

    // back to single-lane
    @(negedge clk);
    dual_mode = 1'b0;
    @(negedge clk);
    check("R8 R4 enables follow single", {28'd0, lane_oe}, 32'hA);
    held_d = lane_dat;
    pd_ok = 1'b1;
    samp_a = 14'h0ABC; samp_b = 14'h3210;
    wait_take();
    get_single(wa, wb, fo, to);
    if (lane_dat[0] !== held_d[0] || lane_dat[2] !== held_d[2]) pd_ok = 1'b0;
    check("R4 lane0 quiet in single", {31'd0, pd_ok}, 32'd1);
    check("R8 restart word on lane1 A", {18'd0, wa}, 32'h0ABC);
    check("R8 restart word on lane1 B", {18'd0, wb}, 32'h3210);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule